// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry-Out

This block shifts or rotates a data word by an amount taken from the low byte of a second operand word. Four kinds of shift are selected by a two-bit code: logical left, logical right, arithmetic right and rotate right. The datapath is purely combinational. When flag update is enabled, the carry output takes the last bit moved out of the word. When flag update is disabled, the incoming carry passes straight through.

Amounts at or beyond the word width follow their own rules for each shift kind, both for the result and for the carry. A zero amount leaves both the word and the carry as they were. The block is meant to sit in an execute stage, between the register read ports and the flag logic.

Top module: `reg_shifter`

## Requirements
- R1: Only bits [7:0] of `amt_i` set the amount (0 to 255). Bits above bit 7 have no effect on `data_o` or `cout_o`.
- R2: An amount of 0 gives `data_o` equal to `data_i` and `cout_o` equal to `cin_i`, for every shift kind.
- R3: Kind code 2'b00 is logical left. For amounts 1 to 31 the result is `data_i` shifted left with zero fill, and the carry is `data_i[32-amount]`. For an amount of 32 the result is 0 and the carry is `data_i[0]`. For amounts above 32 the result and the carry are both 0.
- R4: Kind code 2'b01 is logical right. For amounts 1 to 31 the result is `data_i` shifted right with zero fill, and the carry is `data_i[amount-1]`. For an amount of 32 the result is 0 and the carry is `data_i[31]`. For amounts above 32 the result and the carry are both 0.
- R5: Kind code 2'b10 is arithmetic right. For amounts 1 to 31 the result is `data_i` shifted right with sign fill, and the carry is `data_i[amount-1]`. For any amount of 32 or more, every result bit equals `data_i[31]` and the carry is `data_i[31]`.
- R6: Kind code 2'b11 is rotate right by the amount modulo 32. If that rotation is 0 while the amount is nonzero, the result is unchanged and the carry is `data_i[31]`. Otherwise the carry is `data_i[rotation-1]`.
- R7: With `upd_i` low, `cout_o` equals `cin_i` whatever the kind and the amount. The result is unaffected by `upd_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 32 | Word to shift or rotate |
| amt_i | input | 32 | Operand word; its low byte is the amount |
| kind_i | input | 2 | Shift kind: 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| upd_i | input | 1 | Enables the carry update |
| cin_i | input | 1 | Current carry flag |
| data_o | output | 32 | Shifted or rotated word |
| cout_o | output | 1 | New carry flag |

## Verification
The bench builds the block with its default 32-bit word and 8-bit amount field. With these values the amount range of 0 to 255 covers every regime: zero, in-range, exactly the word width, and past it. It also includes amounts such as 64 and 96, where the rotate count wraps to zero.

Every amount is swept for every kind, against a model that moves one bit per step. This is followed by random words with random upper operand bits, random carries and random flag enables. Directed cases place one-hot and sign-heavy words at the boundary amounts 31, 32 and 33.

// File: rtl/reg_shifter.sv
module reg_shifter #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] amt_i,
  input  logic [1:0]    kind_i,
  input  logic          upd_i,
  input  logic          cin_i,
  output logic [DW-1:0] data_o,
  output logic          cout_o
);
  localparam int SW = $clog2(DW);
  localparam logic [AW-1:0] LIM = AW'(DW);
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [1:0] K_ROR = 2'b11;

  logic [AW-1:0] amt;
  logic [SW-1:0] sh, shm1, negsh;
  logic nz, exact, over;
  logic signed [DW-1:0] sdata;
  logic [2*DW-1:0] dbl;
  logic c;

  assign amt   = amt_i[AW-1:0];
  assign sh    = amt[SW-1:0];
  assign shm1  = sh - SW'(1);
  assign negsh = SW'(0) - sh;
  assign nz    = |amt;
  assign exact = (amt == LIM);
  assign over  = (amt > LIM);
  assign sdata = data_i;
  assign dbl   = {data_i, data_i} >> sh;

  always_comb begin
    data_o = data_i;
    c      = cin_i;
    unique case (kind_i)
      K_LSL: begin
        if (exact || over) data_o = '0;
        else data_o = data_i << sh;
        if (exact) c = data_i[0];
        else if (over) c = 1'b0;
        else if (nz) c = data_i[negsh];
      end
      K_LSR: begin
        if (exact || over) data_o = '0;
        else data_o = data_i >> sh;
        if (exact) c = data_i[DW-1];
        else if (over) c = 1'b0;
        else if (nz) c = data_i[shm1];
      end
      K_ASR: begin
        if (exact || over) begin
          data_o = {DW{data_i[DW-1]}};
          c      = data_i[DW-1];
        end else begin
          data_o = sdata >>> sh;
          if (nz) c = data_i[shm1];
        end
      end
      K_ROR: begin
        if (nz) begin
          if (sh == '0) c = data_i[DW-1];
          else begin
            data_o = dbl[DW-1:0];
            c      = data_i[shm1];
          end
        end
      end
      default: ;
    endcase
  end

  assign cout_o = upd_i ? c : cin_i;
endmodule

module reg_shifter_chk #(
  parameter int DW = 32,
  parameter int AW = 8
) (
  input logic [DW-1:0] data_i,
  input logic [DW-1:0] amt_i,
  input logic [1:0]    kind_i,
  input logic          upd_i,
  input logic          cin_i,
  input logic [DW-1:0] data_o,
  input logic          cout_o
);
  logic [AW-1:0] a;
  assign a = amt_i[AW-1:0];

  always_comb begin
    if (a == '0)
      p_zero_keeps_r2: assert (data_o == data_i && cout_o == cin_i);
    if (!upd_i)
      p_carry_hold_r7: assert (cout_o == cin_i);
    if (kind_i == 2'b00 && a > AW'(DW))
      p_lsl_beyond_r3: assert (data_o == '0 && (!upd_i || !cout_o));
    if (kind_i == 2'b01 && a == AW'(DW))
      p_lsr_exact_r4: assert (data_o == '0 && (!upd_i || cout_o == data_i[DW-1]));
    if (kind_i == 2'b10 && a >= AW'(DW))
      p_asr_fill_r5: assert (data_o == {DW{data_i[DW-1]}} && (!upd_i || cout_o == data_i[DW-1]));
    if (kind_i == 2'b11)
      p_ror_ones_r6: assert ($countones(data_o) == $countones(data_i));
  end
endmodule

bind reg_shifter reg_shifter_chk #(.DW(DW), .AW(AW)) u_chk (
  .data_i(data_i), .amt_i(amt_i), .kind_i(kind_i), .upd_i(upd_i),
  .cin_i(cin_i), .data_o(data_o), .cout_o(cout_o)
);

// File: tb/reg_shifter_tb.sv
module reg_shifter_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [31:0] data_i = '0, amt_i = '0;
  logic [1:0] kind_i = '0;
  logic upd_i = 1'b0, cin_i = 1'b0;
  logic [31:0] data_o;
  logic cout_o;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_shifter u_dut (
    .data_i(data_i), .amt_i(amt_i), .kind_i(kind_i), .upd_i(upd_i),
    .cin_i(cin_i), .data_o(data_o), .cout_o(cout_o)
  );

  function automatic logic [32:0] model(input logic [31:0] d, input logic [31:0] aw,
                                        input logic [1:0] k, input logic u, input logic ci);
    logic [31:0] r = d;
    logic c = ci;
    int n = int'(aw[7:0]);
    case (k)
      2'b00: for (int i = 0; i < n; i++) begin c = r[31]; r = {r[30:0], 1'b0}; end
      2'b01: for (int i = 0; i < n; i++) begin c = r[0]; r = {1'b0, r[31:1]}; end
      2'b10: for (int i = 0; i < n; i++) begin c = r[0]; r = {r[31], r[31:1]}; end
      default: begin
        if (n != 0 && n % 32 == 0) c = d[31];
        for (int i = 0; i < n % 32; i++) begin c = r[0]; r = {r[0], r[31:1]}; end
      end
    endcase
    if (!u) c = ci;
    return {c, r};
  endfunction

  task automatic apply(input logic [31:0] d, input logic [31:0] aw, input logic [1:0] k,
                       input logic u, input logic ci, input string req);
    logic [32:0] exp;
    @(negedge clk);
    data_i = d; amt_i = aw; kind_i = k; upd_i = u; cin_i = ci;
    #1;
    exp = model(d, aw, k, u, ci);
    n_run++;
    if ({cout_o, data_o} !== exp) begin
      n_fail++;
      $display("FAIL %s: kind=%0d amt=%0d d=%h got c=%b r=%h exp c=%b r=%h",
               req, k, aw[7:0], d, cout_o, data_o, exp[32], exp[31:0]);
    end
  endtask

  function automatic string req_of(input logic [1:0] k, input int a, input logic u);
    if (a == 0) return "R2";
    if (!u) return "R7";
    case (k)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    int seed;
    logic [31:0] r0, r1;
    seed = 32'h5eed;
    void'($urandom(seed));
    #1;
    n_run++;
    if (data_o !== 32'h0 || cout_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R2: initial zero amount got r=%h c=%b exp r=0 c=0", data_o, cout_o);
    end
    // full sweep of amounts for each kind (R2..R6)
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 256; a++) begin
        apply(32'h8000_0001 ^ 32'(a * 32'h0101_0357), 32'(a), 2'(k), 1'b1, a[0], req_of(2'(k), a, 1'b1));
        apply(32'h7fff_fffe, 32'(a), 2'(k), 1'b1, 1'b1, req_of(2'(k), a, 1'b1));
        apply(32'hf0f0_0f0f, 32'(a), 2'(k), 1'b1, 1'b0, req_of(2'(k), a, 1'b1));
      end
    // directed boundaries
    for (int k = 0; k < 4; k++)
      for (int a = 31; a < 34; a++) begin
        apply(32'h0000_0001, 32'(a), 2'(k), 1'b1, 1'b1, req_of(2'(k), a, 1'b1));
        apply(32'h8000_0000, 32'(a), 2'(k), 1'b1, 1'b0, req_of(2'(k), a, 1'b1));
        apply(32'hffff_ffff, 32'(a + 64), 2'(k), 1'b1, 1'b0, req_of(2'(k), a, 1'b1));
      end
    // R7: flag update disabled keeps carry
    for (int k = 0; k < 4; k++) begin
      apply(32'hffff_ffff, 32'd32, 2'(k), 1'b0, 1'b0, "R7");
      apply(32'h0000_0000, 32'd33, 2'(k), 1'b0, 1'b1, "R7");
    end
    // R1: upper operand bits ignored, compare two runs directly
    for (int i = 0; i < 64; i++) begin
      logic [31:0] d = $urandom;
      logic [7:0] lo = 8'($urandom);
      logic [1:0] k = 2'($urandom);
      apply(d, {24'h000000, lo}, k, 1'b1, 1'b1, "R1");
      r0 = data_o; r1 = {31'b0, cout_o};
      apply(d, {24'($urandom) | 24'h1, lo}, k, 1'b1, 1'b1, "R1");
      n_run++;
      if (data_o !== r0 || cout_o !== r1[0]) begin
        n_fail++;
        $display("FAIL R1: upper bits changed output got r=%h c=%b exp r=%h c=%b",
                 data_o, cout_o, r0, r1[0]);
      end
    end
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d = $urandom;
      logic [31:0] aw = $urandom;
      logic [1:0] k = 2'($urandom);
      logic u = 1'($urandom);
      logic ci = 1'($urandom);
      if (i % 3 == 0) aw[7:0] = 8'($urandom_range(0, 40));
      apply(d, aw, k, u, ci, req_of(k, int'(aw[7:0]), u));
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule